// File: doc/BRIEF.md
# Banked Scratchpad with Bank-Conflict Serialization

This block is an explicitly managed on-chip scratchpad of 4096 32-bit words (16 KB), spread over 16 word-interleaved banks. A requester presents one access per lane for 16 lanes at once. Each lane has an enable, a word address, a write flag and write data. The storage has no fill or eviction of its own. Whatever a requester writes stays in place until a requester overwrites it.

Every bank can serve one word per cycle. The block therefore splits each request into serial passes. In each pass, every bank serves the lowest-numbered lane still waiting on it. Reads of the identical word by several lanes are merged into that lane's pass as a broadcast, unless a lower-numbered write to the same word is still waiting. A request whose lanes fall in distinct banks finishes in a single pass. A request with heavy bank conflicts takes up to 16 passes. `busy` holds off the requester while the passes run. When the request ends, a one-cycle `done` returns the read data of every lane and the number of passes that were used.

Top module: `sp_banked_scratch`

## Requirements
- R1: After synchronous reset, `busy`, `done`, `pass_count` and all of `rd_data` are 0.
- R2: While `busy` is 0, a request is accepted on the clock edge where `req_valid` is 1, and `busy` is 1 in the following cycle. While `busy` is 1, `req_valid` and all lane inputs are ignored.
- R3: The bank of a word is its address bits [3:0], and the row within the bank is bits [11:4]. Lanes whose enabled addresses all fall in distinct banks complete in one pass.
- R4: For lanes that address different words in the same bank, one pass is spent per distinct access on that bank. The pass count equals the largest number of serialized accesses on any single bank.
- R5: Enabled reads of one identical word, with no lower-numbered enabled write to that word in the same request, are served in a single pass together with the lowest such read.
- R6: The results of a request equal executing its enabled lanes one at a time in ascending lane order. A read sees every write from a lower lane to the same word. When several lanes write one word, the highest lane's data remains.
- R7: `busy` stays 1 for exactly as many cycles as passes are needed. `done` is 1 for the single cycle after the last pass, with `busy` at 0. `pass_count` then holds that number, which lies between 1 and 16.
- R8: `rd_data` lane *k* (bits [32k+31:32k]) holds the word read by lane *k* if that lane was an enabled read. Otherwise it holds 0. The value is kept until the next request is accepted.
- R9: All 4096 words, addresses 0 through 4095, keep written data across requests until they are overwritten.
- R10: A request with no lane enabled takes one pass, reports a `pass_count` of 1 and changes no stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; taken when `busy` is 0 |
| lane_en | input | 16 | Per-lane enable |
| lane_we | input | 16 | Per-lane write flag (1 = write, 0 = read) |
| lane_addr | input | 192 | Word address per lane, 12 bits each, lane k at [12k+11:12k] |
| lane_wdata | input | 512 | Write data per lane, 32 bits each |
| busy | output | 1 | Passes in progress; new requests are ignored |
| done | output | 1 | One-cycle pulse after the last pass |
| rd_data | output | 512 | Read result per lane, 32 bits each |
| pass_count | output | 5 | Passes used by the last completed request |

## Verification
Two situations are hard to reach from the ports. The first is an interleaving where reads and writes to one word are mixed across lanes, so that some reads may be broadcast early and others must wait behind a lower-numbered write. The second is a new request presented while a long conflicted request is still running. For the first, the stimulus table includes a request where four reads, four writes and eight more reads all target one word. The second read group must observe the last of those writes after exactly six passes. For the second, a 16-pass request is launched and a conflicting full write request is driven in its second busy cycle. The words it would have hit are then read back.

// File: rtl/sp_pkg.sv
package sp_pkg;

    localparam int LANES  = 16;
    localparam int BANKS  = 16;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 12;

    localparam int BANK_W = $clog2(BANKS);
    localparam int ROW_W  = ADDR_W - BANK_W;
    localparam int ROWS   = 1 << ROW_W;
    localparam int LANE_W = $clog2(LANES);
    localparam int CNT_W  = $clog2(LANES + 1);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] word_t;
    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [ROW_W-1:0]  row_t;
    typedef logic [LANE_W-1:0] lane_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } sp_state_e;

    typedef struct packed {
        logic  we;
        bank_t bank;
        row_t  row;
        word_t wdata;
    } bank_port_t;

    function automatic bank_t bank_of(input addr_t a);
        return a[BANK_W-1:0];
    endfunction

    function automatic row_t row_of(input addr_t a);
        return a[ADDR_W-1:BANK_W];
    endfunction

endpackage

// File: rtl/sp_pass_sched.sv
module sp_pass_sched
    import sp_pkg::*;
(
    input  logic [LANES-1:0]             pending,
    input  logic [LANES-1:0]             lane_we,
    input  logic [LANES-1:0][ADDR_W-1:0] lane_addr,
    output logic [LANES-1:0]             grant,
    output logic [BANKS-1:0]             bank_act,
    output logic [BANKS-1:0][LANE_W-1:0] bank_lane
);

    logic [LANES-1:0] blocked;

    // Lowest pending lane per bank leads this pass.
    always_comb begin
        for (int b = 0; b < BANKS; b++) begin
            bank_act[b]  = 1'b0;
            bank_lane[b] = '0;
            for (int l = LANES - 1; l >= 0; l--) begin
                if (pending[l] && (bank_of(lane_addr[l]) == BANK_W'(b))) begin
                    bank_act[b]  = 1'b1;
                    bank_lane[b] = LANE_W'(l);
                end
            end
        end
    end

    // A read may not run ahead of a lower pending write to its word.
    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            blocked[j] = 1'b0;
            for (int i = 0; i < j; i++) begin
                if (pending[i] && lane_we[i] && (lane_addr[i] == lane_addr[j]))
                    blocked[j] = 1'b1;
            end
        end
    end

    always_comb begin
        for (int j = 0; j < LANES; j++) begin
            lane_t lead;
            logic  merge;
            lead     = bank_lane[bank_of(lane_addr[j])];
            merge    = !lane_we[j] && !lane_we[lead] && !blocked[j]
                       && (lane_addr[lead] == lane_addr[j]);
            grant[j] = pending[j] && ((lead == LANE_W'(j)) || merge);
        end
    end

endmodule

// File: rtl/sp_bank.sv
module sp_bank
    import sp_pkg::*;
(
    input  logic       clk,
    input  logic       we,
    input  row_t       row,
    input  word_t      wdata,
    output word_t      rdata
);

    word_t mem [ROWS];

    always_ff @(posedge clk) begin
        if (we)
            mem[row] <= wdata;
    end

    assign rdata = mem[row];

endmodule

// File: rtl/sp_banked_scratch.sv
module sp_banked_scratch
    import sp_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [LANES-1:0]         lane_en,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES*ADDR_W-1:0]  lane_addr,
    input  logic [LANES*DATA_W-1:0]  lane_wdata,
    output logic                     busy,
    output logic                     done,
    output logic [LANES*DATA_W-1:0]  rd_data,
    output logic [CNT_W-1:0]         pass_count
);

    sp_state_e                    state_q;
    logic [LANES-1:0]             pending_q;
    logic [LANES-1:0]             we_q;
    logic [LANES-1:0][ADDR_W-1:0] addr_q;
    logic [LANES-1:0][DATA_W-1:0] wdata_q;
    logic [LANES-1:0][DATA_W-1:0] rd_q;
    cnt_t                         cnt_q;
    logic                         done_q;

    logic [LANES-1:0]             pend_eff;
    logic [LANES-1:0]             grant;
    logic [LANES-1:0]             pend_next;
    logic [BANKS-1:0]             bank_act;
    logic [BANKS-1:0][LANE_W-1:0] bank_lane;
    bank_port_t [BANKS-1:0]       bport;
    logic [BANKS-1:0][DATA_W-1:0] bank_rd;
    logic [LANES-1:0][DATA_W-1:0] lane_rd;

    assign pend_eff  = (state_q == ST_RUN) ? pending_q : '0;
    assign pend_next = pending_q & ~grant;

    sp_pass_sched u_sched (
        .pending   (pend_eff),
        .lane_we   (we_q),
        .lane_addr (addr_q),
        .grant     (grant),
        .bank_act  (bank_act),
        .bank_lane (bank_lane)
    );

    genvar gb;
    generate
        for (gb = 0; gb < BANKS; gb++) begin : g_bank
            always_comb begin
                bport[gb].bank  = BANK_W'(gb);
                bport[gb].row   = row_of(addr_q[bank_lane[gb]]);
                bport[gb].wdata = wdata_q[bank_lane[gb]];
                bport[gb].we    = bank_act[gb] && we_q[bank_lane[gb]];
            end

            sp_bank u_bank (
                .clk   (clk),
                .we    (bport[gb].we),
                .row   (bport[gb].row),
                .wdata (bport[gb].wdata),
                .rdata (bank_rd[gb])
            );
        end
    endgenerate

    genvar gl;
    generate
        for (gl = 0; gl < LANES; gl++) begin : g_lane_rd
            assign lane_rd[gl] = bank_rd[bank_of(addr_q[gl])];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            pending_q <= '0;
            we_q      <= '0;
            addr_q    <= '0;
            wdata_q   <= '0;
            rd_q      <= '0;
            cnt_q     <= '0;
            done_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        pending_q <= lane_en;
                        we_q      <= lane_we;
                        addr_q    <= lane_addr;
                        wdata_q   <= lane_wdata;
                        rd_q      <= '0;
                        cnt_q     <= '0;
                        state_q   <= ST_RUN;
                    end
                end
                ST_RUN: begin
                    pending_q <= pend_next;
                    cnt_q     <= cnt_q + 1'b1;
                    for (int j = 0; j < LANES; j++) begin
                        if (grant[j] && !we_q[j])
                            rd_q[j] <= lane_rd[j];
                    end
                    if (pend_next == '0) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state_q == ST_RUN);
    assign done       = done_q;
    assign rd_data    = rd_q;
    assign pass_count = cnt_q;

    // Each pass serves at least one waiting lane (R4)
    assert_pass_progress_R4: assert property (@(posedge clk) disable iff (rst)
        (busy && (pending_q != '0)) |-> (grant != '0));

    // Pending lanes only ever retire, never reappear mid-request (R6)
    assert_pending_shrinks_R6: assert property (@(posedge clk) disable iff (rst)
        busy |=> ((pending_q & ~$past(pending_q)) == '0));

    // Latched request is untouched while passes run (R2)
    assert_busy_ignores_R2: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(we_q) && $stable(addr_q) && $stable(wdata_q)));

    // Completion is flagged exactly when busy ends (R7)
    assert_busy_fall_done_R7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // Reported pass count stays within 1..LANES (R7)
    assert_count_range_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> ((pass_count >= CNT_W'(1)) && (pass_count <= CNT_W'(LANES))));

    // A bank never writes in a pass with no lane leading it (R6)
    assert_bank_write_led_R6: assert property (@(posedge clk) disable iff (rst)
        ($countones(grant & we_q) <= $countones(bank_act)));

endmodule

// File: tb/sp_banked_scratch_test.sv
`timescale 1ns/100ps
module sp_banked_scratch_test;
    import sp_pkg::*;

    logic                         clk = 1'b0;
    logic                         rst;
    logic                         req_valid;
    logic [LANES-1:0]             lane_en;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][ADDR_W-1:0] lane_addr;
    logic [LANES-1:0][DATA_W-1:0] lane_wdata;
    logic                         busy;
    logic                         done;
    logic [LANES-1:0][DATA_W-1:0] rd_data;
    logic [CNT_W-1:0]             pass_count;

    int checks = 0;
    int errors = 0;

    word_t ref_mem [1 << ADDR_W];
    bit    known   [1 << ADDR_W];

    always #2.5 clk = ~clk;

    sp_banked_scratch uut (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .lane_en    (lane_en),
        .lane_we    (lane_we),
        .lane_addr  (lane_addr),
        .lane_wdata (lane_wdata),
        .busy       (busy),
        .done       (done),
        .rd_data    (rd_data),
        .pass_count (pass_count)
    );

    // {enable, write flags, base address, stride, expected passes}
    localparam int NV = 14;
    localparam logic [60:0] VEC [NV] = '{
        {16'hFFFF, 16'hFFFF, 12'd0,  12'd1,  5'd1},
        {16'hFFFF, 16'hFFFF, 12'd16, 12'd1,  5'd1},
        {16'hFFFF, 16'h0000, 12'd0,  12'd1,  5'd1},
        {16'hFFFF, 16'hFFFF, 12'd0,  12'd16, 5'd16},
        {16'hFFFF, 16'h0000, 12'd0,  12'd16, 5'd16},
        {16'hFFFF, 16'h0000, 12'd5,  12'd0,  5'd1},
        {16'hFFFF, 16'hFFFF, 12'd7,  12'd0,  5'd16},
        {16'hFFFF, 16'h0000, 12'd7,  12'd0,  5'd1},
        {16'hFFFF, 16'h0000, 12'd0,  12'd2,  5'd2},
        {16'hFFFF, 16'hFFFF, 12'd0,  12'd8,  5'd8},
        {16'h0003, 16'h0000, 12'd3,  12'd17, 5'd1},
        {16'h0000, 16'h0000, 12'd0,  12'd1,  5'd1},
        {16'hAAAA, 16'h0000, 12'd0,  12'd1,  5'd1},
        {16'hFFFF, 16'h00F0, 12'd9,  12'd0,  5'd6}
    };

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drives one request, runs the sequential reference model, checks results.
    // When inject is set, a conflicting full write to 4000.. is presented mid-run.
    task automatic do_req(input logic [LANES-1:0] en, input logic [LANES-1:0] we,
                          input logic [LANES-1:0][ADDR_W-1:0] ad,
                          input logic [LANES-1:0][DATA_W-1:0] wd,
                          input int exp_passes, input bit inject, input string tag);
        word_t exp_rd [LANES];
        bit    exp_ok [LANES];
        int    cyc;
        for (int l = 0; l < LANES; l++) begin
            exp_rd[l] = '0;
            exp_ok[l] = 1'b1;
            if (en[l]) begin
                if (we[l]) begin
                    ref_mem[ad[l]] = wd[l];
                    known[ad[l]]   = 1'b1;
                end else begin
                    exp_rd[l] = ref_mem[ad[l]];
                    exp_ok[l] = known[ad[l]];
                end
            end
        end
        lane_en    = en;
        lane_we    = we;
        lane_addr  = ad;
        lane_wdata = wd;
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, {"R2 busy after accept ", tag}, 32'(busy), 32'd1);
        cyc = 0;
        while (!done && cyc < 40) begin
            if (busy) cyc++;
            if (inject && cyc == 2) begin
                req_valid = 1'b1;
                lane_en   = '1;
                lane_we   = '1;
                for (int l = 0; l < LANES; l++) begin
                    lane_addr[l]  = ADDR_W'(4000 + l);
                    lane_wdata[l] = 32'hDEAD_0000 + l;
                end
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
        end
        req_valid = 1'b0;
        chk(done == 1'b1 && busy == 1'b0, {"R7 done pulse ", tag}, {busy, done}, 32'd1);
        chk(cyc == exp_passes, {"R7 busy cycles ", tag}, cyc, exp_passes);
        chk(pass_count == CNT_W'(exp_passes), {"R3/R4 pass count ", tag},
            32'(pass_count), exp_passes);
        for (int l = 0; l < LANES; l++) begin
            if (exp_ok[l])
                chk(rd_data[l] === exp_rd[l], {"R5/R6/R8 read data ", tag},
                    rd_data[l], exp_rd[l]);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [LANES-1:0][ADDR_W-1:0] ad;
        logic [LANES-1:0][DATA_W-1:0] wd;
        logic [LANES-1:0][DATA_W-1:0] held;
        for (int a = 0; a < (1 << ADDR_W); a++) known[a] = 1'b0;
        rst = 1'b1;
        req_valid = 1'b0;
        lane_en = '0; lane_we = '0; lane_addr = '0; lane_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy == 1'b0 && done == 1'b0, "R1 busy/done after reset", {busy, done}, 32'd0);
        chk(pass_count == '0, "R1 pass_count after reset", 32'(pass_count), 32'd0);
        chk(rd_data == '0, "R1 rd_data after reset", rd_data[0], 32'd0);

        // Table walk: R3 R4 R5 R6 R8 R10
        for (int v = 0; v < NV; v++) begin
            logic [60:0] e;
            e = VEC[v];
            for (int l = 0; l < LANES; l++) begin
                ad[l] = e[28:17] + ADDR_W'(l) * e[16:5];
                wd[l] = {8'(v), 8'(l), 16'h5A00 + 16'(l)};
            end
            do_req(e[60:45], e[44:29], ad, wd, int'(e[4:0]), 1'b0,
                   $sformatf("vec%0d", v));
        end

        // R8: read data held while idle
        held = rd_data;
        repeat (5) @(negedge clk);
        chk(rd_data == held, "R8 rd_data held while idle", rd_data[1], held[1]);

        // R9: extreme addresses 0 and 4095 in distinct banks, one pass (R3)
        ad = '0; wd = '0;
        ad[0] = 12'd4095; wd[0] = 32'hFACE_0FFF;
        ad[1] = 12'd0;    wd[1] = 32'h0BAD_F00D;
        do_req(16'h0003, 16'h0003, ad, wd, 1, 1'b0, "R9 write ends");
        do_req(16'h0003, 16'h0000, ad, wd, 1, 1'b0, "R9 read ends");
        chk(rd_data[0] == 32'hFACE_0FFF, "R9 word 4095", rd_data[0], 32'hFACE_0FFF);
        chk(rd_data[1] == 32'h0BAD_F00D, "R3 word 0", rd_data[1], 32'h0BAD_F00D);

        // R2: request presented while busy is ignored
        for (int l = 0; l < LANES; l++) begin
            ad[l] = ADDR_W'(4000 + l);
            wd[l] = 32'h1234_0000 + l;
        end
        do_req('1, '1, ad, wd, 1, 1'b0, "R2 preload");
        for (int l = 0; l < LANES; l++) ad[l] = ADDR_W'(l * 16);
        do_req('1, '0, ad, wd, 16, 1'b1, "R2 busy inject");
        chk(busy == 1'b0, "R2 no accept after inject", 32'(busy), 32'd0);
        for (int l = 0; l < LANES; l++) ad[l] = ADDR_W'(4000 + l);
        do_req('1, '0, ad, wd, 1, 1'b0, "R2 readback");
        chk(rd_data[3] == 32'h1234_0003, "R2 injected write absent", rd_data[3],
            32'h1234_0003);

        // R10: empty request leaves word 7 intact
        do_req('0, '1, '0, '0, 1, 1'b0, "R10 empty");
        ad = '0; ad[0] = 12'd7;
        do_req(16'h0001, 16'h0000, ad, wd, 1, 1'b0, "R10 readback");
        chk(rd_data[0] == {8'd6, 8'd15, 16'h5A0F}, "R10/R6 word 7 kept", rd_data[0],
            {8'd6, 8'd15, 16'h5A0F});

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule